// File: doc/BRIEF.md
# AES Byte-Slice Round Step Unit

This execution unit for a 32-bit processor carries out one step of an AES round on a single byte. It takes one byte out of the second operand and passes it through either the forward or the inverse S-box. In the two middle-round variants, the substituted byte is then spread into a four-byte column contribution by GF(2^8) multiplies. The resulting word is rotated so that it lands in the column lane named by the byte select, and it is XORed into the first operand. A program builds a full AES column by running the unit four times, once per byte, and feeding each result back in as the next first operand.

A single register stage holds the result. It loads one cycle after an input strobe, and an output valid flag follows the strobe. The S-box is computed arithmetically, as a field inverse plus an affine map, instead of being stored as a table. Both S-box directions and all field products are evaluated on every operation, so the latency never depends on operand values.

Top module: `aes_byte_round_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `result` are cleared to zero at that edge.
- R2: The operation code is 2'b00 encrypt-final, 2'b01 encrypt-middle, 2'b10 decrypt-final and 2'b11 decrypt-middle. Only `sel[1:0]` picks the source byte of `opb` (0 means bits 7:0, 3 means bits 31:24). The remaining `sel` bits have no effect on the result.
- R3: Encrypt-final substitutes the selected byte s through the forward AES S-box and zero-extends it to 32 bits. The word is rotated left by 8*`sel[1:0]` and XORed with `opa`. Only the selected byte lane of `opa` can change; for example, byte 0x53 gives 0xED.
- R4: Encrypt-middle packs the forward-substituted byte s, from most to least significant byte, as {3·s, s, s, 2·s}. It then rotates the word and XORs it as in R3.
- R5: Decrypt-final behaves like R3 but uses the inverse S-box; for example, byte 0x63 gives 0x00.
- R6: Decrypt-middle packs the inverse-substituted byte s as {0x0B·s, 0x0D·s, 0x09·s, 0x0E·s}. It then rotates the word and XORs it as in R3.
- R7: All products are taken in GF(2^8) reduced by x^8+x^4+x^3+x+1. The field inverse of zero is taken as zero, so S-box(0x00) is 0x63.
- R8: `result` and `out_valid` update exactly one cycle after `in_valid` is sampled high, whatever the data. A cycle with `in_valid` low is followed by `out_valid` low.
- R9: `result` keeps its value in any cycle that follows a cycle with `in_valid` low.
- R10: Operations can be issued on every consecutive cycle, and each one produces its own result in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Operation code (see R2) |
| sel | input | SEL_W (5) | Byte select; only the low two bits are used |
| opa | input | DATA_W (32) | Accumulator operand XORed with the contribution |
| opb | input | DATA_W (32) | Source operand that supplies the byte |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | DATA_W (32) | Registered result |

## Verification
The cases hardest to reach from the ports are the field corner values: input 0x00, which has no multiplicative inverse, and the inverse-direction input 0x63. Random operands seldom put these bytes in every lane under every operation. To cover them, the stimulus sweeps all 256 byte values through both final operations while cycling the lane and filling the unused select bits with random data. It also issues fixed vectors whose values are known independently of any table: 0x53 to 0xED, and the zero-input column words 0xA56363C6 and 0x50A7F451. Random mixed operations are issued back-to-back and separated by idle gaps, so that both the hold behaviour and the valid tracking are exercised.

// File: rtl/aes_slice_pkg.sv
// Package: shared operation codes and GF(2^8) helpers for the AES byte-slice unit.
// Assumes: all helpers are pure combinational functions with fixed loop bounds.
package aes_slice_pkg;

    typedef enum logic [1:0] {
        OP_ENC_FIN = 2'b00,
        OP_ENC_MID = 2'b01,
        OP_DEC_FIN = 2'b10,
        OP_DEC_MID = 2'b11
    } slice_op_e;

    localparam logic [7:0] GF_RED    = 8'h1B;  // low byte of x^8+x^4+x^3+x+1
    localparam logic [7:0] AFF_FWD_C = 8'h63;
    localparam logic [7:0] AFF_INV_C = 8'h05;

    // Multiply by x in the field.
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (GF_RED & {8{a[7]}});
    endfunction

    // Full field multiply, masked accumulate with no data-dependent control.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] t;
        acc = 8'h00;
        t   = a;
        for (int i = 0; i < 8; i++) begin
            acc = acc ^ (t & {8{b[i]}});
            t   = gf_dbl(t);
        end
        return acc;
    endfunction

    // Field inverse as a^254 (zero maps to zero).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] acc;
        sq  = a;
        acc = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        return acc;
    endfunction

    // Rotate a byte left by a constant amount.
    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        return 8'((x << n) | (x >> (8 - n)));
    endfunction

endpackage

// File: rtl/aes_lane_pick.sv
// Module: extracts one byte lane of a word.
// Assumes: DATA_W is a multiple of 8 and LANE_W bits address every lane.
module aes_lane_pick #(
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        byte_out
);
    logic [7:0] lanes [BYTES];

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign lanes[i] = word_in[8*i +: 8];
    end

    // Route the addressed lane to the output.
    always_comb byte_out = lanes[lane];

endmodule

// File: rtl/aes_sbox_dual.sv
// Module: forward and inverse AES S-box, computed arithmetically.
// Assumes: both directions are always evaluated and the select only muxes them,
// so the path delay never depends on the data.
module aes_sbox_dual
    import aes_slice_pkg::*;
(
    input  logic [7:0] x,
    input  logic       inverse,
    output logic [7:0] y
);
    logic [7:0] fwd_inv;
    logic [7:0] fwd_out;
    logic [7:0] inv_pre;
    logic [7:0] inv_out;

    // Forward path: field inverse followed by the affine map.
    always_comb begin
        fwd_inv = gf_inv(x);
        fwd_out = fwd_inv ^ rotl8(fwd_inv, 1) ^ rotl8(fwd_inv, 2)
                ^ rotl8(fwd_inv, 3) ^ rotl8(fwd_inv, 4) ^ AFF_FWD_C;
    end

    // Inverse path: inverse affine map followed by the field inverse.
    always_comb begin
        inv_pre = rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ AFF_INV_C;
        inv_out = gf_inv(inv_pre);
    end

    // Select the requested direction.
    always_comb y = inverse ? inv_out : fwd_out;

endmodule

// File: rtl/aes_col_word.sv
// Module: builds the column contribution of one substituted byte and rotates it
// into the selected lane.
// Assumes: the column pattern is four bytes; wider words are zero-extended.
module aes_col_word
    import aes_slice_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [7:0]        s,
    input  logic              middle,
    input  logic              decrypt,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] word_out
);
    logic [31:0]       col_enc;
    logic [31:0]       col_dec;
    logic [31:0]       col;
    logic [DATA_W-1:0] col_ext;
    logic [DATA_W-1:0] rot_opts [BYTES];

    // Both middle-round patterns are always computed.
    always_comb begin
        col_enc = {gf_mul(s, 8'h03), s, s, gf_mul(s, 8'h02)};
        col_dec = {gf_mul(s, 8'h0B), gf_mul(s, 8'h0D), gf_mul(s, 8'h09), gf_mul(s, 8'h0E)};
    end

    // Pick the final or middle pattern for the requested direction.
    always_comb begin
        if (!middle) col = {24'h0, s};
        else         col = decrypt ? col_dec : col_enc;
        col_ext = DATA_W'(col);
    end

    for (genvar k = 0; k < BYTES; k++) begin : g_rot
        if (k == 0) begin : g_id
            assign rot_opts[k] = col_ext;
        end else begin : g_sh
            assign rot_opts[k] = {col_ext[DATA_W-8*k-1:0], col_ext[DATA_W-1 -: 8*k]};
        end
    end

    // Rotate left by whole lanes.
    always_comb word_out = rot_opts[lane];

    // R4 R6: the XOR of the four column bytes equals s for both middle patterns.
    always_comb begin
        if (middle) begin
            mid_parity_chk: assert ((col[31:24] ^ col[23:16] ^ col[15:8] ^ col[7:0]) == s);
        end
    end

endmodule

// File: rtl/aes_byte_round_unit.sv
// Module: top of the AES byte-slice round step unit. It picks a byte, substitutes
// it, forms the column contribution, XORs it into opa and registers the result.
// Assumes: a single fixed-latency stage; no backpressure at the output.
module aes_byte_round_unit
    import aes_slice_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 5,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam logic [DATA_W-1:0] LANE_MASK0 = DATA_W'(8'hFF);

    slice_op_e         op_e;
    logic [LANE_W-1:0] lane;
    logic [7:0]        src_byte;
    logic [7:0]        sub_byte;
    logic [DATA_W-1:0] contrib;

    // Decode the operation code and the used select bits.
    always_comb begin
        op_e = slice_op_e'(op);
        lane = sel[LANE_W-1:0];
    end

    aes_lane_pick #(.DATA_W(DATA_W)) i_pick (
        .word_in  (opb),
        .lane     (lane),
        .byte_out (src_byte)
    );

    aes_sbox_dual i_sbox (
        .x       (src_byte),
        .inverse (op_e == OP_DEC_FIN || op_e == OP_DEC_MID),
        .y       (sub_byte)
    );

    aes_col_word #(.DATA_W(DATA_W)) i_col (
        .s        (sub_byte),
        .middle   (op_e == OP_ENC_MID || op_e == OP_DEC_MID),
        .decrypt  (op_e == OP_DEC_FIN || op_e == OP_DEC_MID),
        .lane     (lane),
        .word_out (contrib)
    );

    // Output stage: load on strobe, track valid, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= opa ^ contrib;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R3 R5
    final_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op[0]) |=>
        (((result ^ $past(opa)) & ~(LANE_MASK0 << (8 * $past(sel[LANE_W-1:0])))) == '0));

endmodule

// File: tb/test_aes_byte_round_unit.sv
// Scoreboard bench: a driver task queues expected results, a monitor pops and compares them.
module test_aes_byte_round_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [4:0]  sel = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] result;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] last_res = '0;
    logic [7:0]  fwd_t [256];
    logic [7:0]  inv_t [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_byte_round_unit i_aes_byte_round_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sel(sel),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    // Reference field multiply: carry-less product then polynomial reduction (R7).
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11B << (i - 8));
        return p[7:0];
    endfunction

    // Build reference S-box tables by inverse search and a bitwise affine map.
    task automatic build_tables();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] iv;
            logic [7:0] o;
            logic [7:0] c;
            iv = 8'h00;
            for (int b = 1; b < 256; b++) if (m_mul(8'(a), 8'(b)) == 8'h01) iv = 8'(b);
            c = 8'h63;
            for (int i = 0; i < 8; i++)
                o[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8] ^ iv[(i+7)%8] ^ c[i];
            fwd_t[a] = o;
        end
        for (int a = 0; a < 256; a++) inv_t[fwd_t[a]] = 8'(a);
    endtask

    function automatic logic [31:0] model(input logic [1:0] o, input logic [4:0] s_in,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [7:0]  x;
        logic [7:0]  s;
        logic [31:0] w;
        x = b[8*s_in[1:0] +: 8];
        s = o[1] ? inv_t[x] : fwd_t[x];
        case (o)
            2'b00, 2'b10: w = {24'h0, s};
            2'b01:        w = {m_mul(s, 8'h03), s, s, m_mul(s, 8'h02)};
            default:      w = {m_mul(s, 8'h0B), m_mul(s, 8'h0D), m_mul(s, 8'h09), m_mul(s, 8'h0E)};
        endcase
        for (int k = 0; k < int'(s_in[1:0]); k++) w = {w[23:0], w[31:24]};
        return a ^ w;
    endfunction

    // Driver: present one operation and queue its expected result.
    task automatic issue_exp(input logic [1:0] o, input logic [4:0] s_in, input logic [31:0] a,
                             input logic [31:0] b, input logic [31:0] e, input string tag);
        @(negedge clk);
        in_valid = 1'b1; op = o; sel = s_in; opa = a; opb = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic issue(input logic [1:0] o, input logic [4:0] s_in, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        issue_exp(o, s_in, a, b, model(o, s_in, a, b), tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opa = $urandom; opb = $urandom; op = 2'($urandom); sel = 5'($urandom);
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare valid results in order, and check holding while idle.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected out_valid", 32'(out_valid), 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(result === e, t, result, e);
                end
                last_res = result;
            end else begin
                check(result === last_res, "R9 hold while idle", result, last_res);
            end
        end
    end

    initial begin
        build_tables();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid === 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);
        check(result === 32'h0, "R1 result after reset", result, 32'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // Fixed vectors independent of the reference tables (R3 R5 R4 R6 R7).
        issue_exp(2'b00, 5'd0, 32'h0, 32'h53, 32'h000000ED, "R3 sbox(53)");
        issue_exp(2'b00, 5'd0, 32'h0, 32'h0, 32'h00000063, "R7 sbox(00)");
        issue_exp(2'b10, 5'd2, 32'h0, 32'h00630000, 32'h00000000, "R5 invsbox(63)");
        issue_exp(2'b01, 5'd0, 32'h0, 32'h0, 32'hA56363C6, "R4 column of 00");
        issue_exp(2'b11, 5'd0, 32'h0, 32'h0, 32'h50A7F451, "R6 column of 00");
        issue_exp(2'b01, 5'd1, 32'h0, 32'h0, 32'h6363C6A5, "R4 rotated lane1");
        idle(3);

        // Every operation under every lane, junk in the upper select bits (R2 R3 R4 R5 R6).
        for (int o = 0; o < 4; o++) begin
            for (int k = 0; k < 4; k++) begin
                for (int r = 0; r < 4; r++) begin
                    logic [4:0] s_in;
                    s_in = {3'($urandom), 2'(k)};
                    issue(2'(o), s_in, $urandom, $urandom,
                          o == 0 ? "R3 enc-final" : o == 1 ? "R4 enc-middle" :
                          o == 2 ? "R5 dec-final" : "R6 dec-middle");
                end
            end
            idle(2);
        end

        // Upper select bits ignored: same operands, differing high select bits (R2).
        for (int i = 0; i < 8; i++) issue(2'b11, {3'(i), 2'b10}, 32'h1234_5678, 32'h9ABC_DEF0, "R2 high sel ignored");
        idle(2);

        // Byte sweep through both final operations, back-to-back (R7 R10).
        for (int v = 0; v < 256; v++) begin
            issue(2'b00, {3'($urandom), 2'(v)}, $urandom, {4{8'(v)}}, "R7 fwd sweep");
            issue(2'b10, {3'($urandom), 2'(v)}, $urandom, {4{8'(v)}}, "R10 inv sweep");
        end
        idle(1);

        // Mixed random traffic with gaps (R8 R10).
        for (int i = 0; i < 200; i++) begin
            issue(2'($urandom), 5'($urandom), $urandom, $urandom, "R10 mixed");
            if ($urandom % 4 == 0) idle(1 + ($urandom % 3));
        end
        idle(3);
        check(exp_q.size() == 0, "R8 all results returned", 32'(exp_q.size()), 32'h0);

        // Reset in the middle of traffic clears the stage (R1).
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; opa = 32'hFFFF_FFFF;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid under reset", 32'(out_valid), 32'h0);
        check(result === 32'h0, "R1 result under reset", result, 32'h0);
        in_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        done = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule